// File: doc/BRIEF.md
# Oversampled DAC Code Sequencer

This block turns a 12-bit two's-complement drive code into the two digital streams that feed a split DAC: an 8-bit coarse word, sign included, for a multi-bit converter, and a one-bit pulse stream that carries the four low-order bits. The coarse word is reloaded on every coarse tick. The four fine bits are played out one per slot, most significant first. Each slot has its own high window, and the window length follows the weight of the bit. Over one fine cycle the pulse stream therefore averages to exactly the value of the low nibble, and the coarse word plus that average gives the full 12-bit level.

All timing comes from one system clock. A chain of three clock-enable dividers makes the coarse tick (every `COARSE_DIV` clocks), the slot boundary (every `TICKS_PER_SLOT` ticks) and the fine-cycle boundary (every `FINE_W` slots). A code written on `code_valid` is first held in a staging register. It becomes the live code only at a fine-cycle boundary, so one pass never mixes bits from two codes. With `COARSE_ONLY` set, the channel behaves as an 8-bit one: the low bits of every code are forced to zero and the pulse output stays low.

The pulse stream is produced by a two-state machine. `ST_REST` holds the output low and is the reset state. `ST_DRIVE` holds it high. At every slot boundary the machine enters `ST_DRIVE` if the bit of the slot that is starting is 1; otherwise it enters `ST_REST`. At the start of a fine cycle, that bit is the top fine bit of the newly committed code. Inside a slot, `ST_DRIVE` falls back to `ST_REST` when the bit's weighted window runs out. The top bit's window fills the whole slot, so for that bit the only exit is at the slot boundary.

Top module: `dac_code_sequencer`

## Requirements
- R1: While reset is asserted, and after it is released, `coarse_word` is 0 and `fine_pwm` and `cycle_start` are low. The first `cycle_start` pulse appears in clock `CYCLE_CLKS` after release, counting the first clock after release as clock 1.
- R2: `coarse_word` equals bits [11:4] of the live code, with bit 7 carrying the sign. It is reloaded on each coarse tick and changes only in the clock where `cycle_start` is high.
- R3: A fine cycle lasts `CYCLE_CLKS = FINE_W * COARSE_DIV * TICKS_PER_SLOT` clocks. `cycle_start` is high for exactly its first clock and low in all other clocks.
- R4: Slot k of a fine cycle (k = 0 first) carries code bit 3-k, so the fine bits go out from bit 3 down to bit 0.
- R5: In slot k, `fine_pwm` is high for the first `SLOT_CLKS >> k` clocks if the carried bit is 1, and low for the rest of the slot; it is low for the whole slot if the bit is 0. Over a fine cycle the high-clock count is therefore `(SLOT_CLKS/8) * code[3:0]`.
- R6: A code presented with `code_valid` high does not change any output before the next fine-cycle start. If several codes are written within one fine cycle, the last one takes effect.
- R7: A code written in the last clock of a fine cycle takes effect in the fine cycle that begins in the following clock.
- R8: With `COARSE_ONLY` = 1, `fine_pwm` stays low for every code, and `coarse_word` behaves as in R2.
- R9: `fine_pwm` is never high past the weighted window of the slot it is in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| code_valid | input | 1 | Write strobe for `code` |
| code | input | 12 (CODE_W) | Two's-complement drive code |
| coarse_word | output | 8 (CODE_W-FINE_W) | Coarse DAC word, sign in MSB |
| fine_pwm | output | 1 | One-bit weighted pulse stream for the low bits |
| cycle_start | output | 1 | High in the first clock of each fine cycle |

## Verification
The interesting coincidence is a write strobe that lands on the same clock edge as the fine-cycle commit. In that case the staging register is bypassed, and the fresh code has to reach both the coarse word and the first fine slot at once. The sweep provokes this on every other vector by raising `code_valid` in the last clock of a cycle. The other vectors write in the fifth clock instead. Each following cycle is judged clock by clock against the coarse field, the slot-by-slot pulse window and the high-clock count, all computed from the written code. A separate cycle writes two codes to confirm that the last write wins.

// File: rtl/dacseq_pkg.sv
package dacseq_pkg;

    typedef enum logic {
        ST_REST  = 1'b0,
        ST_DRIVE = 1'b1
    } fine_state_e;

    // High-window length of slot k: the slot length halved once per slot position.
    function automatic int unsigned weight_clks(input int unsigned slot_clks,
                                                input int unsigned slot_pos);
        return slot_clks >> slot_pos;
    endfunction

endpackage

// File: rtl/dacseq_divider.sv
module dacseq_divider #(
    parameter int unsigned DIV = 4,
    localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [CNT_W-1:0] count,
    output logic             last
);

    assign last = step && (count == CNT_W'(DIV - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (step) begin
            count <= last ? '0 : count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/dacseq_shadow.sv
module dacseq_shadow #(
    parameter int unsigned CODE_W      = 12,
    parameter int unsigned FINE_W      = 4,
    parameter bit          COARSE_ONLY = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              commit,
    output logic [CODE_W-1:0] live_code,
    output logic [CODE_W-1:0] upcoming
);

    logic [CODE_W-1:0] staged_q;
    logic [CODE_W-1:0] live_q;
    logic [CODE_W-1:0] pick;
    logic [CODE_W-1:0] masked;

    // A write on the commit edge bypasses the staging register.
    assign pick = wr_en ? wr_code : staged_q;

    generate
        if (COARSE_ONLY) begin : g_coarse_only
            assign masked = {pick[CODE_W-1:FINE_W], {FINE_W{1'b0}}};
        end else begin : g_full
            assign masked = pick;
        end
    endgenerate

    assign upcoming  = commit ? masked : live_q;
    assign live_code = live_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged_q <= '0;
            live_q   <= '0;
        end else begin
            if (wr_en) begin
                staged_q <= wr_code;
            end
            if (commit) begin
                live_q <= masked;
            end
        end
    end

    // R6: the live code holds steady between cycle boundaries
    a_r6_live_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(live_q));

endmodule

// File: rtl/dacseq_fine_fsm.sv
module dacseq_fine_fsm
    import dacseq_pkg::*;
#(
    parameter int unsigned FINE_W    = 4,
    parameter int unsigned SLOT_CLKS = 8,
    localparam int unsigned IDX_W = (FINE_W > 1) ? $clog2(FINE_W) : 1,
    localparam int unsigned OFF_W = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  slot_idx,
    input  logic [OFF_W-1:0]  slot_off,
    input  logic              slot_end,
    input  logic              cycle_end,
    input  logic [FINE_W-1:0] live_bits,
    input  logic [FINE_W-1:0] next_bits,
    output logic              fine_pwm
);

    fine_state_e state_q;
    fine_state_e state_d;
    logic        cur_bit;
    logic        nxt_bit;
    logic [OFF_W-1:0] win_last;

    // Decode the bit carried by the current slot, the bit of the slot
    // that follows, and the last offset of the current weighted window.
    always_comb begin
        cur_bit  = 1'b0;
        nxt_bit  = next_bits[FINE_W-1];
        win_last = '0;
        for (int k = 0; k < FINE_W; k++) begin
            if (int'(slot_idx) == k) begin
                cur_bit  = live_bits[FINE_W-1-k];
                win_last = OFF_W'(weight_clks(SLOT_CLKS, k) - 1);
            end
            if (!cycle_end && (int'(slot_idx) + 1 == k)) begin
                nxt_bit = live_bits[FINE_W-1-k];
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DRIVE: begin
                if (slot_end) begin
                    state_d = nxt_bit ? ST_DRIVE : ST_REST;
                end else if (slot_off == win_last) begin
                    state_d = ST_REST;
                end
            end
            ST_REST: begin
                if (slot_end) begin
                    state_d = nxt_bit ? ST_DRIVE : ST_REST;
                end
            end
            default: state_d = ST_REST;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_REST;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode
    always_comb begin
        fine_pwm = (state_q == ST_DRIVE);
    end

    // R4: a high slot always belongs to a set bit of the live code
    a_r4_drive_needs_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRIVE) |-> cur_bit);

    // R9: the pulse never runs past its weighted window
    a_r9_within_window: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRIVE) |-> (slot_off <= win_last));

endmodule

// File: rtl/dac_code_sequencer.sv
module dac_code_sequencer #(
    parameter int unsigned CODE_W         = 12,
    parameter int unsigned FINE_W         = 4,
    parameter int unsigned COARSE_DIV     = 50,
    parameter int unsigned TICKS_PER_SLOT = 4,
    parameter bit          COARSE_ONLY    = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     code_valid,
    input  logic [CODE_W-1:0]        code,
    output logic [CODE_W-FINE_W-1:0] coarse_word,
    output logic                     fine_pwm,
    output logic                     cycle_start
);

    localparam int unsigned COARSE_W  = CODE_W - FINE_W;
    localparam int unsigned SLOT_CLKS = COARSE_DIV * TICKS_PER_SLOT;
    localparam int unsigned DIV_W     = (COARSE_DIV > 1) ? $clog2(COARSE_DIV) : 1;
    localparam int unsigned TPS_W     = (TICKS_PER_SLOT > 1) ? $clog2(TICKS_PER_SLOT) : 1;
    localparam int unsigned IDX_W     = (FINE_W > 1) ? $clog2(FINE_W) : 1;
    localparam int unsigned OFF_W     = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;

    logic [DIV_W-1:0]  div_cnt;
    logic [TPS_W-1:0]  tick_cnt;
    logic [IDX_W-1:0]  slot_idx;
    logic              coarse_tick;
    logic              slot_end;
    logic              cycle_end;
    logic [OFF_W-1:0]  slot_off;
    logic [CODE_W-1:0] live_code;
    logic [CODE_W-1:0] upcoming;
    logic [COARSE_W-1:0] coarse_q;
    logic              start_q;

    dacseq_divider #(.DIV(COARSE_DIV)) u_coarse_div (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (1'b1),
        .count (div_cnt),
        .last  (coarse_tick)
    );

    dacseq_divider #(.DIV(TICKS_PER_SLOT)) u_slot_div (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (coarse_tick),
        .count (tick_cnt),
        .last  (slot_end)
    );

    dacseq_divider #(.DIV(FINE_W)) u_cycle_div (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (slot_end),
        .count (slot_idx),
        .last  (cycle_end)
    );

    assign slot_off = OFF_W'(tick_cnt) * OFF_W'(COARSE_DIV) + OFF_W'(div_cnt);

    dacseq_shadow #(
        .CODE_W      (CODE_W),
        .FINE_W      (FINE_W),
        .COARSE_ONLY (COARSE_ONLY)
    ) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (code_valid),
        .wr_code   (code),
        .commit    (cycle_end),
        .live_code (live_code),
        .upcoming  (upcoming)
    );

    dacseq_fine_fsm #(
        .FINE_W    (FINE_W),
        .SLOT_CLKS (SLOT_CLKS)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_idx  (slot_idx),
        .slot_off  (slot_off),
        .slot_end  (slot_end),
        .cycle_end (cycle_end),
        .live_bits (live_code[FINE_W-1:0]),
        .next_bits (upcoming[FINE_W-1:0]),
        .fine_pwm  (fine_pwm)
    );

    // Coarse word reloads on every coarse tick; cycle marker registers the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coarse_q <= '0;
            start_q  <= 1'b0;
        end else begin
            if (coarse_tick) begin
                coarse_q <= upcoming[CODE_W-1 -: COARSE_W];
            end
            start_q <= cycle_end;
        end
    end

    assign coarse_word = coarse_q;
    assign cycle_start = start_q;

    // R2: the coarse word only moves together with the cycle marker
    a_r2_coarse_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(coarse_word) |-> cycle_start);

    // R3: the cycle marker is a single-clock pulse
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |=> !cycle_start);

    generate
        if (COARSE_ONLY) begin : g_chk_coarse_only
            // R8: an 8-bit channel never emits a fine pulse
            a_r8_no_fine_pulse: assert property (@(posedge clk) disable iff (!rst_n)
                !fine_pwm);
        end
    endgenerate

endmodule

// File: tb/dac_code_sequencer_tb_top.sv
module dac_code_sequencer_tb_top;

    localparam int CW   = 12;
    localparam int FW   = 4;
    localparam int CDIV = 2;
    localparam int TPS  = 4;
    localparam int SLOT = CDIV * TPS;
    localparam int CYC  = SLOT * FW;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n;
    logic          code_valid;
    logic [CW-1:0] code;
    logic [CW-FW-1:0] coarse_a, coarse_b;
    logic          pwm_a, pwm_b, cs_a, cs_b;

    int n_vec = 0;
    int n_bad = 0;

    dac_code_sequencer #(
        .CODE_W(CW), .FINE_W(FW), .COARSE_DIV(CDIV), .TICKS_PER_SLOT(TPS), .COARSE_ONLY(1'b0)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .code_valid(code_valid), .code(code),
        .coarse_word(coarse_a), .fine_pwm(pwm_a), .cycle_start(cs_a)
    );

    dac_code_sequencer #(
        .CODE_W(CW), .FINE_W(FW), .COARSE_DIV(CDIV), .TICKS_PER_SLOT(TPS), .COARSE_ONLY(1'b1)
    ) dut8_i (
        .clk(clk), .rst_n(rst_n), .code_valid(code_valid), .code(code),
        .coarse_word(coarse_b), .fine_pwm(pwm_b), .cycle_start(cs_b)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [CW-1:0] code_of(input int v);
        return CW'((v * 1237 + 291) % 4096);
    endfunction

    // Entered at the sample point of a cycle's first clock; checks the whole
    // cycle against cur and drives up to two writes. Leaves at the next first clock.
    task automatic run_cycle(input logic [CW-1:0] cur,
                             input int wr1_pos, input logic [CW-1:0] wr1_code,
                             input int wr2_pos, input logic [CW-1:0] wr2_code);
        int highs = 0;
        for (int p = 0; p < CYC; p++) begin
            int s   = p / SLOT;
            int off = p % SLOT;
            int hi  = SLOT >> s;
            logic exp_pwm = cur[FW-1-s] && (off < hi);
            if (p > 0) @(negedge clk);
            check("R4/R5 fine pulse", 32'(pwm_a), 32'(exp_pwm));
            check("R8 coarse-only pulse", 32'(pwm_b), 32'd0);
            check("R2/R6 coarse word", 32'(coarse_a), 32'(cur[CW-1:FW]));
            check("R8 coarse-only word", 32'(coarse_b), 32'(cur[CW-1:FW]));
            check("R3 cycle marker", 32'(cs_a), 32'(p == 0));
            check("R3 cycle marker 8-bit", 32'(cs_b), 32'(p == 0));
            if (pwm_a) highs++;
            if (p == wr1_pos) begin
                code_valid = 1'b1;
                code       = wr1_code;
            end else if (p == wr2_pos) begin
                code_valid = 1'b1;
                code       = wr2_code;
            end else begin
                code_valid = 1'b0;
            end
        end
        check("R5 high-clock count", 32'(highs), 32'((SLOT / 8) * int'(cur[FW-1:0])));
        @(negedge clk);
        code_valid = 1'b0;
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [CW-1:0] cur;
        rst_n      = 1'b0;
        code_valid = 1'b0;
        code       = '0;
        repeat (5) @(negedge clk);
        check("R1 reset coarse", 32'(coarse_a), 32'd0);
        check("R1 reset pulse", 32'(pwm_a), 32'd0);
        check("R1 reset marker", 32'(cs_a), 32'd0);
        rst_n = 1'b1;

        // R1: the first cycle runs with code zero and the marker comes at clock CYC.
        for (int n = 1; n <= CYC; n++) begin
            @(negedge clk);
            check("R1 first marker", 32'(cs_a), 32'(n == CYC));
            if (n < CYC) begin
                check("R1 idle pulse", 32'(pwm_a), 32'd0);
                check("R1 idle coarse", 32'(coarse_a), 32'd0);
            end
            code_valid = (n == 10);
            code       = code_of(0);
        end
        code_valid = 1'b0;

        // Full sweep: writes alternate between mid-cycle (R6) and the last clock (R7).
        for (int v = 0; v < 4096; v++) begin
            run_cycle(code_of(v), (v % 2 == 1) ? CYC - 1 : 5, code_of(v + 1), -1, '0);
        end

        // R6: two writes in one cycle, the later one wins.
        cur = code_of(4096);
        run_cycle(cur, 3, 12'h2A5, 10, 12'hD3B);
        run_cycle(12'hD3B, -1, '0, -1, '0);

        // R7: boundary write of extreme codes.
        run_cycle(12'hD3B, CYC - 1, 12'h800, -1, '0);
        run_cycle(12'h800, CYC - 1, 12'h7FF, -1, '0);
        run_cycle(12'h7FF, CYC - 1, 12'hFFF, -1, '0);
        run_cycle(12'hFFF, -1, '0, -1, '0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule